// File: doc/BRIEF.md
# I2C Target Front End with Transaction Watchdog

This block is the serial configuration port of a register-programmed device. It listens on a two-wire I2C bus as a target at one fixed 7-bit address, 7'b1101010 (0x6A). It oversamples the clock and data lines with the faster system clock, cleans them up, and finds START, repeated START and STOP conditions. It acknowledges its own address and then moves bytes to and from an external register file through a plain address / write-data / write-enable / read-data port. It pulls SDA low only through an open-drain enable.

After a write address, the first data byte loads an internal register pointer. Each following byte is written at the pointer, and the pointer then steps forward. A read begins at the current pointer. It sends the register MSB first and steps the pointer after every byte, until the controller answers with a NACK. A watchdog times every transfer from its START or repeated START. If no STOP arrives within a set number of system clocks, the watchdog sends the protocol engine back to idle and emits a one-cycle pulse. The engine then ignores the bus until the next START, so a stuck controller cannot hold the port.

Top module: `i2c_cfg_target`

## Requirements
- R1: START is a falling SDA while SCL is high, and STOP is a rising SDA while SCL is high. A START or repeated START always begins a new address phase. After a STOP, clocked bits are ignored until the next START: there is no acknowledge and no register write.
- R2: The eighth bit of the first byte is R/W (0 = write, 1 = read), and address 0x6A is acknowledged by holding SDA low through the high phase of the ninth SCL pulse. Any other address is not acknowledged, and its whole transaction causes no register write. After reset, SDA is released.
- R3: In a write, the first byte after the address sets the pointer. Each later byte is acknowledged and appears on reg_wdata with reg_addr equal to the pointer, during one cycle of reg_we. The pointer then increments and wraps from 0xFF to 0x00.
- R4: In a read, the byte on reg_rdata at reg_addr is sent MSB first, and the pointer increments after each byte. A controller ACK continues with the next register. A NACK ends the read, and SDA stays released until STOP or START, so further clocked bits read as 1.
- R5: The target changes SDA only while SCL is low, outside of START, STOP and timeout handling.
- R6: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks does not change the bytes received.
- R7: The transaction timer starts at START, restarts at every repeated START and stops at STOP. If it counts TMO_CYC clocks without a STOP, timeout_pulse is high for exactly one cycle.
- R8: After a timeout, the engine releases SDA, acknowledges nothing and writes nothing until the next START. The next START is then served normally.
- R9: The same logic serves SCL periods of 40 and 160 system clocks, which stand for 400 kbit/s and 100 kbit/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_addr | output | PTR_W | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register file contents at reg_addr |
| timeout_pulse | output | 1 | One-cycle pulse on watchdog expiry |

## Verification
The assertions check on every cycle the rules that hold at any instant:
- SDA holds still while the filtered SCL is high.
- The write strobe lasts one cycle, and the pointer steps right after it.
- The timeout pulse lasts one cycle and never follows a STOP.
- SDA and the strobe go quiet after a timeout.
- The filter output follows only a settled input.

Only the bench scenarios can show the byte-level behaviour:
- which of the 128 addresses is acknowledged;
- the pointer wrap;
- the data read back after a repeated START;
- the released line after a NACK;
- the rejection of short glitches;
- that a repeated START keeps a long transfer alive, while a stalled one is cut off and the port recovers.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RXPTR,
    ST_RXDAT,
    ST_TXDAT,
    ST_MACK,
    ST_IGNORE
  } eng_st_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int STAGES   = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [STAGES-1:0] sy;
  logic [CW-1:0]     cnt;
  logic              settled_in;

  assign settled_in = sy[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sy   <= '1;
      cnt  <= '0;
      dout <= 1'b1;
    end else begin
      sy <= {sy[STAGES-2:0], din};
      if (settled_in != dout) begin
        if (cnt == CW'(FILT_LEN - 1)) begin
          dout <= settled_in;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // R6: the output only ever moves to the value the synchronised input held
  a_r6_follow_settled: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> (dout == $past(settled_in)));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start,
  output logic stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start    = scl_f & scl_q & sda_q & ~sda_f;
  assign stop     = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
endmodule

// File: rtl/i2c_txn_timer.sv
module i2c_txn_timer #(
  parameter int TMO_CYC = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  output logic expire
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic          running;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (stop) begin
        running <= 1'b0;
      end else if (running) begin
        if (cnt == TW'(TMO_CYC - 1)) begin
          running <= 1'b0;
          expire  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: expiry is a single-cycle pulse
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);
  // R7: a STOP halts the timer, so no expiry follows it
  a_r7_stop_halts: assert property (@(posedge clk) disable iff (rst)
    stop |=> !expire);
endmodule

// File: rtl/i2c_proto_engine.sv
module i2c_proto_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start,
  input  logic              stop,
  input  logic              tmo,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata
);
  eng_st_e           state, after_ack;
  logic [BYTE_W-1:0] shreg;
  logic [3:0]        bitcnt;
  logic              mack;
  logic              rx_state;
  logic              byte_done;

  assign rx_state  = (state == ST_ADDR) || (state == ST_RXPTR) || (state == ST_RXDAT);
  assign byte_done = rx_state && scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) reg_addr <= reg_addr + 1'b1;
      if (start) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (tmo) begin
        state  <= ST_IGNORE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        if (rx_state && scl_rise) begin
          shreg  <= {shreg[BYTE_W-2:0], sda_f};
          bitcnt <= bitcnt + 1'b1;
        end
        if (byte_done) begin
          bitcnt <= '0;
          unique case (state)
            ST_ADDR: begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                after_ack <= shreg[0] ? ST_TXDAT : ST_RXPTR;
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_RXPTR: begin
              reg_addr  <= shreg[PTR_W-1:0];
              sda_oe    <= 1'b1;
              state     <= ST_ACK;
              after_ack <= ST_RXDAT;
            end
            default: begin
              reg_we    <= 1'b1;
              reg_wdata <= shreg;
              sda_oe    <= 1'b1;
              state     <= ST_ACK;
              after_ack <= ST_RXDAT;
            end
          endcase
        end else if (scl_fall) begin
          case (state)
            ST_ACK: begin
              bitcnt <= '0;
              if (after_ack == ST_TXDAT) begin
                shreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
              end else begin
                sda_oe <= 1'b0;
              end
              state <= after_ack;
            end
            ST_TXDAT: begin
              if (bitcnt == 4'd7) begin
                sda_oe   <= 1'b0;
                reg_addr <= reg_addr + 1'b1;
                bitcnt   <= '0;
                state    <= ST_MACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[6];
                bitcnt <= bitcnt + 1'b1;
              end
            end
            ST_MACK: begin
              if (mack) begin
                shreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                state  <= ST_TXDAT;
              end else begin
                state <= ST_IGNORE;
              end
            end
            default: ;
          endcase
        end else if (scl_rise && state == ST_MACK) begin
          mack <= ~sda_f;
        end
      end
    end
  end

  // R5: SDA drive holds while SCL is high, except on START, STOP or timeout
  a_r5_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    (scl_f && !start && !stop && !tmo) |=> $stable(sda_oe));
  // R3: the write strobe lasts one cycle
  a_r3_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  // R3: the pointer steps right after each write
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !start && !stop && !tmo) |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));
  // R8: a timeout leaves the bus released and writes nothing
  a_r8_quiet_after_tmo: assert property (@(posedge clk) disable iff (rst)
    tmo |=> (!sda_oe && !reg_we));
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         TMO_CYC     = 200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              timeout_pulse
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines, filt_lines;
  logic start, stop, scl_rise, scl_fall;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_line_filter #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(filt_lines[g])
    );
  end

  i2c_bus_events u_evt (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (filt_lines[0]),
    .sda_f   (filt_lines[1]),
    .start   (start),
    .stop    (stop),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  i2c_txn_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .stop  (stop),
    .expire(timeout_pulse)
  );

  i2c_proto_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (filt_lines[0]),
    .sda_f    (filt_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start    (start),
    .stop     (stop),
    .tmo      (timeout_pulse),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
  );
endmodule

// File: tb/sim_i2c_cfg_target.sv
module sim_i2c_cfg_target;
  localparam int CLK_NS = 10;
  localparam int TMO    = 12000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_i, sda_oe, reg_we, timeout_pulse;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int n_chk = 0, n_err = 0, hp = 20, r5_bad = 0;
  int we_count = 0, pulses = 0, wide = 0;
  logic prev_pulse = 1'b0;
  logic glitch_scl = 1'b0, glitch_sda = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  assign sda_i     = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_cfg_target #(.TMO_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_i), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .timeout_pulse(timeout_pulse)
  );

  always_ff @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_count <= we_count + 1;
    end
    if (!rst && timeout_pulse) pulses <= pulses + 1;
    if (timeout_pulse && prev_pulse) wide <= wide + 1;
    prev_pulse <= timeout_pulse;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int p, input int i, input int seed);
    return 8'((p * 13 + i * 29 + seed * 71 + 5) & 255);
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; wclk(hp);
    sda_m = 1'b0; wclk(hp);
    scl_m = 1'b0; wclk(hp/2);
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; wclk(hp/2);
    scl_m = 1'b1; wclk(hp);
    sda_m = 1'b0; wclk(hp);
    scl_m = 1'b0; wclk(hp/2);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wclk(hp/2);
    scl_m = 1'b1; wclk(hp);
    sda_m = 1'b1; wclk(hp);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    logic s1, s2;
    sda_m = b; wclk(hp/2);
    scl_m = 1'b1;
    if (glitch_scl) begin
      wclk(6); scl_m = 1'b0; wclk(2); scl_m = 1'b1; wclk(hp/2 - 8);
    end else if (glitch_sda) begin
      wclk(6); sda_m = ~b; wclk(2); sda_m = b; wclk(hp/2 - 8);
    end else begin
      wclk(hp/2);
    end
    s1 = sda_i;
    wclk(hp/2 - 1);
    s2 = sda_i;
    if (s1 !== s2) r5_bad++;
    wclk(1);
    scl_m = 1'b0; wclk(hp/2);
    s = s1;
  endtask

  task automatic wbyte(input logic [7:0] d, input logic [7:0] gs, input logic [7:0] gd,
                       output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      glitch_scl = gs[i]; glitch_sda = gd[i];
      bus_bit(d[i], s);
    end
    glitch_scl = 1'b0; glitch_sda = 1'b0;
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(~give_ack, s);
  endtask

  task automatic wr_seq(input int p, input int len, input int seed, input string tag);
    logic ack;
    int w0;
    w0 = we_count;
    i2c_start();
    wbyte(8'hD4, 8'h00, 8'h00, ack); chk(ack, {tag, " addr ack"}, ack, 1);
    wbyte(8'(p), 8'h00, 8'h00, ack); chk(ack, {tag, " ptr ack"}, ack, 1);
    for (int i = 0; i < len; i++) begin
      exp_mem[(p + i) & 255] = pat(p, i, seed);
      wbyte(pat(p, i, seed), 8'h00, 8'h00, ack);
      chk(ack, {tag, " data ack"}, ack, 1);
    end
    i2c_stop();
    chk(we_count - w0 == len, {tag, " write count"}, we_count - w0, len);
    for (int i = 0; i < len; i++)
      chk(mem[(p + i) & 255] == exp_mem[(p + i) & 255], {tag, " stored byte"},
          mem[(p + i) & 255], exp_mem[(p + i) & 255]);
  endtask

  task automatic rd_seq(input int p, input int len, input string tag);
    logic ack;
    logic [7:0] d;
    i2c_start();
    wbyte(8'hD4, 8'h00, 8'h00, ack); chk(ack, {tag, " addr ack"}, ack, 1);
    wbyte(8'(p), 8'h00, 8'h00, ack); chk(ack, {tag, " ptr ack"}, ack, 1);
    i2c_rstart();
    wbyte(8'hD5, 8'h00, 8'h00, ack); chk(ack, "R1 repeated START read addr ack", ack, 1);
    for (int i = 0; i < len; i++) begin
      rbyte(i < len - 1, d);
      chk(d == exp_mem[(p + i) & 255], {tag, " read byte"}, d, exp_mem[(p + i) & 255]);
    end
    rbyte(1'b0, d);
    chk(d == 8'hFF, "R4 released after NACK", d, 8'hFF);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic ack;
    int w0, p0;
    wclk(20);
    rst = 1'b0;
    wclk(10);
    chk(!sda_oe && !reg_we && !timeout_pulse, "R2 reset idle",
        {sda_oe, reg_we, timeout_pulse}, 0);

    // R2: every address, write direction
    hp = 20;
    for (int a = 0; a < 128; a++) begin
      i2c_start();
      wbyte(8'(a << 1), 8'h00, 8'h00, ack);
      i2c_stop();
      chk(ack == (a == 'h6A), "R2 address sweep", ack, a == 'h6A);
    end

    // R2: a transaction to another address writes nothing
    w0 = we_count;
    i2c_start();
    wbyte(8'hD6, 8'h00, 8'h00, ack); chk(!ack, "R2 foreign addr no ack", ack, 0);
    wbyte(8'h10, 8'h00, 8'h00, ack); chk(!ack, "R2 foreign ptr no ack", ack, 0);
    wbyte(8'h77, 8'h00, 8'h00, ack); chk(!ack, "R2 foreign data no ack", ack, 0);
    i2c_stop();
    chk(we_count == w0, "R2 foreign no write", we_count - w0, 0);

    // R3 writes, including wrap past 0xFF; R4 reads
    wr_seq(8'h10, 1, 1, "R3");
    wr_seq(8'h20, 3, 2, "R3");
    wr_seq(8'hFE, 4, 3, "R3 wrap");
    rd_seq(8'h20, 3, "R4");
    rd_seq(8'hFE, 4, "R4 wrap");

    // R6: short glitches on SCL and SDA inside data bits
    w0 = we_count;
    i2c_start();
    wbyte(8'hD4, 8'h00, 8'h00, ack);
    wbyte(8'h30, 8'h00, 8'h00, ack);
    wbyte(8'hA5, 8'h81, 8'h00, ack); chk(ack, "R6 glitched byte ack", ack, 1);
    wbyte(8'h3C, 8'h00, 8'h24, ack); chk(ack, "R6 glitched byte ack", ack, 1);
    i2c_stop();
    chk(mem[8'h30] == 8'hA5, "R6 SCL glitch ignored", mem[8'h30], 8'hA5);
    chk(mem[8'h31] == 8'h3C, "R6 SDA glitch ignored", mem[8'h31], 8'h3C);
    chk(we_count - w0 == 2, "R6 write count", we_count - w0, 2);

    // R1: bits after STOP without a START are ignored
    w0 = we_count;
    wbyte(8'hD4, 8'h00, 8'h00, ack); chk(!ack, "R1 no ack after STOP", ack, 0);
    wbyte(8'h40, 8'h00, 8'h00, ack);
    wbyte(8'h11, 8'h00, 8'h00, ack);
    i2c_stop();
    chk(we_count == w0, "R1 no write after STOP", we_count - w0, 0);

    // R9: slow bus rate
    hp = 80;
    wr_seq(8'h50, 3, 4, "R9");
    rd_seq(8'h50, 2, "R9");
    hp = 20;

    // R7/R8: stalled transfer times out
    p0 = pulses;
    w0 = we_count;
    i2c_start();
    wbyte(8'hD4, 8'h00, 8'h00, ack);
    wbyte(8'h40, 8'h00, 8'h00, ack);
    wclk(13000);
    chk(pulses - p0 == 1, "R7 timeout fires once", pulses - p0, 1);
    chk(!sda_oe, "R8 SDA released after timeout", sda_oe, 0);
    wbyte(8'h99, 8'h00, 8'h00, ack); chk(!ack, "R8 no ack after timeout", ack, 0);
    wbyte(8'h98, 8'h00, 8'h00, ack);
    i2c_stop();
    chk(we_count == w0, "R8 no write after timeout", we_count - w0, 0);
    wr_seq(8'h40, 1, 5, "R8 recovery");

    // R7: repeated START restarts the timer
    p0 = pulses;
    i2c_start();
    wbyte(8'hD4, 8'h00, 8'h00, ack);
    wclk(7000);
    i2c_rstart();
    wbyte(8'hD4, 8'h00, 8'h00, ack); chk(ack, "R7 ack after late repeated START", ack, 1);
    wclk(7000);
    i2c_stop();
    chk(pulses == p0, "R7 repeated START restarts timer", pulses - p0, 0);

    // R7: STOP halts the timer
    i2c_start();
    wbyte(8'hD4, 8'h00, 8'h00, ack);
    i2c_stop();
    wclk(13000);
    chk(pulses == p0, "R7 STOP halts timer", pulses - p0, 0);
    chk(wide == 0, "R7 pulse width one cycle", wide, 0);
    chk(r5_bad == 0, "R5 SDA stable while SCL high", r5_bad, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule